// File: doc/BRIEF.md
# Pixel-to-Lane Word Mapper

This block sits between a parallel video source and a bank of 7:1 serializers. On every pixel clock it takes one pixel, made of red, green and blue samples, horizontal and vertical sync, a data-enable flag and two auxiliary control bits. From that pixel it builds five 7-bit lane words, named A to E, which the serializers then shift out. Two bit orderings are available at run time: one that puts the most significant colour bits first and one that puts the least significant bits first. Two colour depths are also available, 8 and 10 bits per sample.

During horizontal and vertical blanking (data-enable low), only a chosen set of colour bit positions may carry side-channel data. Every other colour bit is zeroed. On the first and last pixel of each blanking run, the side-channel positions are zeroed as well. Telling that a pixel is the last one of a run needs one pixel of look-ahead. For that reason the block holds each pixel for one clock, and its lane words lag the input by exactly one pixel clock. During active video the sync outputs keep the values they had on the last blanking pixel. When the output is disabled or the link is not locked, all lane words go to zero, and a flag tells the pad logic to tri-state. A run-length monitor flags any active or blanking run that is shorter than the minimum the link allows.

Top module: `pix_lane_mapper`

## Requirements
- R1: Lane C bit 6 carries the data-enable of the pixel presented one clock earlier. Lane C bit 4 carries that pixel's horizontal sync and bit 5 its vertical sync (subject to R9). This holds in every format and depth.
- R2: When fmt_jeida_i=1 and deep_i=0 (8-bit samples in bits 7:0), the lanes are built as follows. Lane A bits 5:0 = R[7:2] and bit 6 = G[2]. Lane B bits 4:0 = G[7:3] and bits 6:5 = B[3:2]. Lane C bits 3:0 = B[7:4]. Lane D bits 5:0 = {B[1:0], G[1:0], R[1:0]}.
- R3: When fmt_jeida_i=0 and deep_i=0, the lanes are built as follows. Lane A bits 5:0 = R[5:0] and bit 6 = G[0]. Lane B bits 4:0 = G[5:1] and bits 6:5 = B[1:0]. Lane C bits 3:0 = B[5:2]. Lane D bits 5:0 = {B[7:6], G[7:6], R[7:6]}.
- R4: When deep_i=0, lane D bit 6 is 0, lane E is all zero and lane_e_on_o is 0. When deep_i=1, lane_e_on_o is 1, lane D bit 6 carries aux_i[0] and lane E bit 6 carries aux_i[1].
- R5: When fmt_jeida_i=0 and deep_i=1, lanes A to D are built as in R3 from bits 7:0, and lane E bits 5:0 = {B[9:8], G[9:8], R[9:8]}.
- R6: When fmt_jeida_i=1 and deep_i=1, lanes A to D are built as in R2 from bits 9:2 (each sample shifted down by two), and lane E bits 5:0 = {B[1:0], G[1:0], R[1:0]}.
- R7: On a blanking pixel that is neither the first nor the last of its run, all blue bits pass unchanged. R[1:0], G[1:0] and both aux bits also pass, but only in 10-bit mode. Every other colour bit is forced to 0.
- R8: On the first and on the last pixel of a blanking run, every colour bit and both aux bits are forced to 0. A pixel is first when the pixel before it had data-enable high, and last when the pixel after it has data-enable high. Before reset, history counts as data-enable low.
- R9: While the output pixel has data-enable high, lane C bits 5:4 show the vertical and horizontal sync of the most recent blanking pixel (0 if there has been none since reset).
- R10: When oe_i=0 or lock_i=0, all five lane words are zero. In that state hiz_o equals the inverse of pat_low_i. Whenever oe_i=1 and lock_i=1, hiz_o is 0.
- R11: run_err_o pulses high for one clock when the output pixel is the first of a new data-enable run and the run just ended was shorter than MIN_RUN pixels. The run in progress at reset is exempt.
- R12: While reset is asserted, all lane words, hiz_o (with the link enabled) and run_err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| r_i | input | COL_W | Red sample (8-bit mode uses bits 7:0) |
| g_i | input | COL_W | Green sample |
| b_i | input | COL_W | Blue sample |
| hs_i | input | 1 | Horizontal sync |
| vs_i | input | 1 | Vertical sync |
| de_i | input | 1 | Data enable, high in active video |
| aux_i | input | 2 | Auxiliary control bits |
| fmt_jeida_i | input | 1 | 1 = most significant bits first ordering, 0 = least significant first |
| deep_i | input | 1 | 1 = 10-bit samples, 0 = 8-bit |
| oe_i | input | 1 | Output enable |
| lock_i | input | 1 | Link locked |
| pat_low_i | input | 1 | Disabled-state pattern: 1 = drive zero, 0 = request high impedance |
| lane_a_o | output | LANE_W | Lane A word |
| lane_b_o | output | LANE_W | Lane B word |
| lane_c_o | output | LANE_W | Lane C word (sync and data enable in bits 6:4) |
| lane_d_o | output | LANE_W | Lane D word |
| lane_e_o | output | LANE_W | Lane E word |
| lane_e_on_o | output | 1 | Lane E in use (10-bit mode) |
| hiz_o | output | 1 | Request to tri-state the lane drivers |
| run_err_o | output | 1 | Short data-enable run detected |

## Verification
The properties take the format, depth and pattern selects as static over the two clocks each one compares. They also assume oe_i and lock_i are high in both cycles when they relate an output to an earlier input. The stimulus therefore changes the mode selects only between frames, and it toggles the enables only in long, steady runs. Random frames keep every active and blanking run at or above eight pixels, so run_err_o stays low there. Short runs, including a run of exactly seven next to runs of exactly eight, are applied only in a directed section whose expected flag pulses are computed from the run lengths.

// File: rtl/plm_pkg.sv
package plm_pkg;

   localparam int unsigned PIX_COL_W = 10;   // widest colour sample supported
   localparam int unsigned LANE_BITS = 7;    // bits per serializer word
   localparam int unsigned AUX_BITS  = 2;
   localparam int unsigned NUM_CH    = 3;
   localparam int unsigned CH_R      = 0;
   localparam int unsigned CH_G      = 1;
   localparam int unsigned CH_B      = 2;

   typedef struct packed {
      logic [NUM_CH-1:0][PIX_COL_W-1:0] col;
      logic                             hs;
      logic                             vs;
      logic                             de;
      logic [AUX_BITS-1:0]              aux;
   } pix_t;

   typedef logic [LANE_BITS-1:0] lane_t;

endpackage

// File: rtl/plm_stage.sv
// One-pixel holding stage: supplies the look-behind and look-ahead
// data-enable context and the sync values latched during blanking.
module plm_stage
   import plm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  pix_t pix_in,
   output pix_t pix_cur,
   output logic first_low,
   output logic last_low,
   output logic hs_eff,
   output logic vs_eff
);

   pix_t cur_q;
   logic de_before_q;
   logic hs_hold_q;
   logic vs_hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q       <= '0;
         de_before_q <= 1'b0;
         hs_hold_q   <= 1'b0;
         vs_hold_q   <= 1'b0;
      end else begin
         cur_q       <= pix_in;
         de_before_q <= cur_q.de;
         if (!cur_q.de) begin
            hs_hold_q <= cur_q.hs;
            vs_hold_q <= cur_q.vs;
         end
      end
   end

   assign pix_cur   = cur_q;
   assign first_low = !cur_q.de && de_before_q;
   assign last_low  = !cur_q.de && pix_in.de;
   assign hs_eff    = cur_q.de ? hs_hold_q : cur_q.hs;
   assign vs_eff    = cur_q.de ? vs_hold_q : cur_q.vs;

endmodule

// File: rtl/plm_blank_mask.sv
// Applies the blanking rules in the pixel domain, before any lane mapping.
module plm_blank_mask
   import plm_pkg::*;
(
   input  pix_t cur,
   input  logic first_low,
   input  logic last_low,
   input  logic hs_eff,
   input  logic vs_eff,
   input  logic deep,
   output pix_t gated
);

   localparam int unsigned SIDE_LSBS = 2;   // low R/G bits usable in 10-bit blanking

   logic                             edge_px;
   logic [NUM_CH-1:0][PIX_COL_W-1:0] keep;
   logic [NUM_CH-1:0][PIX_COL_W-1:0] col_g;

   assign edge_px = first_low | last_low;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      if (c == CH_B) begin : g_side_all
         assign keep[c] = {PIX_COL_W{1'b1}};
      end else begin : g_side_low
         assign keep[c] = deep ? {{(PIX_COL_W-SIDE_LSBS){1'b0}}, {SIDE_LSBS{1'b1}}}
                               : {PIX_COL_W{1'b0}};
      end
      assign col_g[c] = cur.de  ? cur.col[c] :
                        edge_px ? {PIX_COL_W{1'b0}} :
                                  (cur.col[c] & keep[c]);
   end

   always_comb begin
      gated     = cur;
      gated.col = col_g;
      gated.hs  = hs_eff;
      gated.vs  = vs_eff;
      gated.aux = (cur.de || (deep && !edge_px)) ? cur.aux : '0;
   end

endmodule

// File: rtl/plm_lane_pack.sv
// Splits each colour sample into a six-bit and a two-bit field plus the
// extension pair, then packs the fields into the five lane words.
module plm_lane_pack
   import plm_pkg::*;
(
   input  pix_t  px,
   input  logic  jeida,
   input  logic  deep,
   output lane_t lane_a,
   output lane_t lane_b,
   output lane_t lane_c,
   output lane_t lane_d,
   output lane_t lane_e
);

   localparam int unsigned CORE_W = 8;
   localparam int unsigned SIX_W  = 6;
   localparam int unsigned TWO_W  = CORE_W - SIX_W;
   localparam int unsigned EXT_W  = PIX_COL_W - CORE_W;

   logic [NUM_CH-1:0][CORE_W-1:0] core;
   logic [NUM_CH-1:0][SIX_W-1:0]  six;
   logic [NUM_CH-1:0][TWO_W-1:0]  two;
   logic [NUM_CH-1:0][EXT_W-1:0]  ext;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_split
      assign core[c] = (jeida && deep) ? px.col[c][PIX_COL_W-1 -: CORE_W]
                                       : px.col[c][CORE_W-1:0];
      assign six[c]  = jeida ? core[c][CORE_W-1 -: SIX_W] : core[c][SIX_W-1:0];
      assign two[c]  = jeida ? core[c][TWO_W-1:0]         : core[c][CORE_W-1 -: TWO_W];
      assign ext[c]  = jeida ? px.col[c][EXT_W-1:0]       : px.col[c][PIX_COL_W-1 -: EXT_W];
   end

   always_comb begin
      lane_a = {six[CH_G][0], six[CH_R]};
      lane_b = {six[CH_B][1:0], six[CH_G][SIX_W-1:1]};
      lane_c = {px.de, px.vs, px.hs, six[CH_B][SIX_W-1:2]};
      lane_d = {deep & px.aux[0], two[CH_B], two[CH_G], two[CH_R]};
      lane_e = deep ? {px.aux[1], ext[CH_B], ext[CH_G], ext[CH_R]} : '0;
   end

endmodule

// File: rtl/plm_run_check.sv
// Measures data-enable run lengths at the holding stage and flags short runs.
module plm_run_check #(
   parameter int unsigned MIN_RUN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic de_nxt,
   input  logic de_now,
   output logic short_run
);

   localparam int unsigned CNT_W = $clog2(MIN_RUN + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_RUN);

   logic [CNT_W-1:0] len_q;
   logic             seen_q;
   logic             flip;

   assign flip = de_nxt != de_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q     <= '0;
         seen_q    <= 1'b0;
         short_run <= 1'b0;
      end else begin
         short_run <= flip && seen_q && (len_q < CNT_MAX);
         if (flip) begin
            seen_q <= 1'b1;
            len_q  <= CNT_W'(1);
         end else if (len_q < CNT_MAX) begin
            len_q  <= len_q + CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/pix_lane_mapper.sv
module pix_lane_mapper
   import plm_pkg::*;
#(
   parameter int unsigned COL_W   = 10,
   parameter int unsigned LANE_W  = 7,
   parameter int unsigned MIN_RUN = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [COL_W-1:0]  r_i,
   input  logic [COL_W-1:0]  g_i,
   input  logic [COL_W-1:0]  b_i,
   input  logic              hs_i,
   input  logic              vs_i,
   input  logic              de_i,
   input  logic [1:0]        aux_i,
   input  logic              fmt_jeida_i,
   input  logic              deep_i,
   input  logic              oe_i,
   input  logic              lock_i,
   input  logic              pat_low_i,
   output logic [LANE_W-1:0] lane_a_o,
   output logic [LANE_W-1:0] lane_b_o,
   output logic [LANE_W-1:0] lane_c_o,
   output logic [LANE_W-1:0] lane_d_o,
   output logic [LANE_W-1:0] lane_e_o,
   output logic              lane_e_on_o,
   output logic              hiz_o,
   output logic              run_err_o
);

   if (COL_W != PIX_COL_W) begin : g_bad_col_w
      $error("pix_lane_mapper: COL_W must equal the package sample width");
   end
   if (LANE_W != LANE_BITS) begin : g_bad_lane_w
      $error("pix_lane_mapper: LANE_W must equal the package lane width");
   end
   if (MIN_RUN < 2) begin : g_bad_min_run
      $error("pix_lane_mapper: MIN_RUN must be at least 2");
   end

   pix_t  pix_in;
   pix_t  pix_cur;
   pix_t  pix_gated;
   logic  first_low;
   logic  last_low;
   logic  hs_eff;
   logic  vs_eff;
   logic  out_on;
   lane_t w_a, w_b, w_c, w_d, w_e;

   always_comb begin
      pix_in           = '0;
      pix_in.col[CH_R] = r_i;
      pix_in.col[CH_G] = g_i;
      pix_in.col[CH_B] = b_i;
      pix_in.hs        = hs_i;
      pix_in.vs        = vs_i;
      pix_in.de        = de_i;
      pix_in.aux       = aux_i;
   end

   plm_stage u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .pix_in    (pix_in),
      .pix_cur   (pix_cur),
      .first_low (first_low),
      .last_low  (last_low),
      .hs_eff    (hs_eff),
      .vs_eff    (vs_eff)
   );

   plm_blank_mask u_mask (
      .cur       (pix_cur),
      .first_low (first_low),
      .last_low  (last_low),
      .hs_eff    (hs_eff),
      .vs_eff    (vs_eff),
      .deep      (deep_i),
      .gated     (pix_gated)
   );

   plm_lane_pack u_pack (
      .px     (pix_gated),
      .jeida  (fmt_jeida_i),
      .deep   (deep_i),
      .lane_a (w_a),
      .lane_b (w_b),
      .lane_c (w_c),
      .lane_d (w_d),
      .lane_e (w_e)
   );

   plm_run_check #(.MIN_RUN(MIN_RUN)) u_runs (
      .clk       (clk),
      .rst_n     (rst_n),
      .de_nxt    (de_i),
      .de_now    (pix_cur.de),
      .short_run (run_err_o)
   );

   assign out_on = oe_i & lock_i;

   always_comb begin
      lane_a_o    = out_on ? w_a : '0;
      lane_b_o    = out_on ? w_b : '0;
      lane_c_o    = out_on ? w_c : '0;
      lane_d_o    = out_on ? w_d : '0;
      lane_e_o    = out_on ? w_e : '0;
      hiz_o       = !out_on && !pat_low_i;
      lane_e_on_o = deep_i;
   end

endmodule

// File: rtl/pix_lane_mapper_chk.sv
module pix_lane_mapper_chk #(
   parameter int unsigned LANE_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              de_i,
   input logic              deep_i,
   input logic              oe_i,
   input logic              lock_i,
   input logic              pat_low_i,
   input logic [LANE_W-1:0] lane_a_o,
   input logic [LANE_W-1:0] lane_b_o,
   input logic [LANE_W-1:0] lane_c_o,
   input logic [LANE_W-1:0] lane_d_o,
   input logic [LANE_W-1:0] lane_e_o,
   input logic              lane_e_on_o,
   input logic              hiz_o,
   input logic              run_err_o
);

   logic arm1_q;
   logic arm2_q;
   logic out_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm1_q <= 1'b0;
         arm2_q <= 1'b0;
      end else begin
         arm1_q <= 1'b1;
         arm2_q <= arm1_q;
      end
   end

   assign out_on = oe_i & lock_i;

   // R1: data-enable lane bit follows the input by one clock
   p_de_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (arm1_q && out_on) |-> (lane_c_o[6] == $past(de_i)));

   // R4: 8-bit mode leaves lane E and lane D bit 6 idle
   p_lane_e_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !deep_i |-> (lane_e_o == '0 && !lane_d_o[6] && !lane_e_on_o));

   // R8: aux positions are zero on the first blanking pixel
   p_first_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (arm1_q && out_on && $past(out_on) && deep_i && !lane_c_o[6] && $past(lane_c_o[6]))
      |-> (!lane_d_o[6] && !lane_e_o[6]));

   // R9: sync bits stay put across consecutive active pixels
   p_sync_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (arm1_q && out_on && $past(out_on) && lane_c_o[6] && $past(lane_c_o[6]))
      |-> (lane_c_o[5:4] == $past(lane_c_o[5:4])));

   // R10: disabled output is quiet and the tri-state request follows the pattern select
   p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !out_on |-> ({lane_a_o, lane_b_o, lane_c_o, lane_d_o, lane_e_o} == '0
                   && hiz_o == !pat_low_i));

   // R11: a short-run pulse only follows a data-enable change
   p_err_on_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (arm2_q && run_err_o) |-> ($past(de_i) != $past(de_i, 2)));

endmodule

bind pix_lane_mapper pix_lane_mapper_chk #(.LANE_W(LANE_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .de_i        (de_i),
   .deep_i      (deep_i),
   .oe_i        (oe_i),
   .lock_i      (lock_i),
   .pat_low_i   (pat_low_i),
   .lane_a_o    (lane_a_o),
   .lane_b_o    (lane_b_o),
   .lane_c_o    (lane_c_o),
   .lane_d_o    (lane_d_o),
   .lane_e_o    (lane_e_o),
   .lane_e_on_o (lane_e_on_o),
   .hiz_o       (hiz_o),
   .run_err_o   (run_err_o)
);

// File: tb/pix_lane_mapper_tb_top.sv
`timescale 1ns/1ps
module pix_lane_mapper_tb_top;

   typedef struct packed {
      logic [9:0] r;
      logic [9:0] g;
      logic [9:0] b;
      logic       hs;
      logic       vs;
      logic       de;
      logic [1:0] aux;
   } tpx_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] r_i = '0, g_i = '0, b_i = '0;
   logic       hs_i = 1'b0, vs_i = 1'b0, de_i = 1'b0;
   logic [1:0] aux_i = '0;
   logic       fmt_jeida_i = 1'b1, deep_i = 1'b0;
   logic       oe_i = 1'b1, lock_i = 1'b1, pat_low_i = 1'b1;
   logic [6:0] lane_a_o, lane_b_o, lane_c_o, lane_d_o, lane_e_o;
   logic       lane_e_on_o, hiz_o, run_err_o;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;

   // reference model state
   tpx_t m_cur;
   logic m_prevde, m_hhs, m_hvs, m_err;
   int   m_len;
   bit   m_seen;

   always #2 clk = ~clk;

   pix_lane_mapper dut_i (
      .clk(clk), .rst_n(rst_n), .r_i(r_i), .g_i(g_i), .b_i(b_i),
      .hs_i(hs_i), .vs_i(vs_i), .de_i(de_i), .aux_i(aux_i),
      .fmt_jeida_i(fmt_jeida_i), .deep_i(deep_i), .oe_i(oe_i), .lock_i(lock_i),
      .pat_low_i(pat_low_i), .lane_a_o(lane_a_o), .lane_b_o(lane_b_o),
      .lane_c_o(lane_c_o), .lane_d_o(lane_d_o), .lane_e_o(lane_e_o),
      .lane_e_on_o(lane_e_on_o), .hiz_o(hiz_o), .run_err_o(run_err_o)
   );

   task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [34:0] exp_words(input tpx_t c, input logic prevde, input logic nxtde,
                                             input logic hhs, input logic hvs,
                                             input logic jeida, input logic deep);
      logic       edge_px;
      logic [9:0] r, g, b;
      logic [1:0] ax;
      logic       hs, vs;
      logic [6:0] a, bb, cc, d, e;
      edge_px = !c.de && (prevde || nxtde);
      if (c.de) begin
         r = c.r; g = c.g; b = c.b; ax = c.aux; hs = hhs; vs = hvs;
      end else begin
         hs = c.hs; vs = c.vs;
         r  = (deep && !edge_px) ? (c.r & 10'h003) : 10'h000;
         g  = (deep && !edge_px) ? (c.g & 10'h003) : 10'h000;
         b  = edge_px ? 10'h000 : c.b;
         ax = (deep && !edge_px) ? c.aux : 2'b00;
      end
      case ({jeida, deep})
         2'b10: begin
            a = {g[2], r[7:2]}; bb = {b[3:2], g[7:3]}; cc = {c.de, vs, hs, b[7:4]};
            d = {1'b0, b[1], b[0], g[1], g[0], r[1], r[0]}; e = 7'h00;
         end
         2'b11: begin
            a = {g[4], r[9:4]}; bb = {b[5:4], g[9:5]}; cc = {c.de, vs, hs, b[9:6]};
            d = {ax[0], b[3], b[2], g[3], g[2], r[3], r[2]};
            e = {ax[1], b[1], b[0], g[1], g[0], r[1], r[0]};
         end
         2'b00: begin
            a = {g[0], r[5:0]}; bb = {b[1:0], g[5:1]}; cc = {c.de, vs, hs, b[5:2]};
            d = {1'b0, b[7], b[6], g[7], g[6], r[7], r[6]}; e = 7'h00;
         end
         default: begin
            a = {g[0], r[5:0]}; bb = {b[1:0], g[5:1]}; cc = {c.de, vs, hs, b[5:2]};
            d = {ax[0], b[7], b[6], g[7], g[6], r[7], r[6]};
            e = {ax[1], b[9], b[8], g[9], g[8], r[9], r[8]};
         end
      endcase
      return {a, bb, cc, d, e};
   endfunction

   function automatic tpx_t mk(input logic de);
      tpx_t p;
      p.r   = 10'($urandom);
      p.g   = 10'($urandom);
      p.b   = 10'($urandom);
      p.hs  = 1'($urandom);
      p.vs  = 1'($urandom);
      p.aux = 2'($urandom);
      p.de  = de;
      return p;
   endfunction

   // called just after a rising edge: drive, check at the falling edge, advance model
   task automatic step(input tpx_t p);
      logic        en;
      logic [34:0] ew;
      string       tag;
      r_i = p.r; g_i = p.g; b_i = p.b; hs_i = p.hs; vs_i = p.vs; de_i = p.de; aux_i = p.aux;
      @(negedge clk);
      en = oe_i & lock_i;
      ew = en ? exp_words(m_cur, m_prevde, p.de, m_hhs, m_hvs, fmt_jeida_i, deep_i) : 35'h0;
      if (!en)                         tag = "R10 words";
      else if (!m_cur.de)              tag = (m_prevde || p.de) ? "R8 edge blank" : "R7 blank";
      else if (fmt_jeida_i && !deep_i) tag = "R2 map";
      else if (!deep_i)                tag = "R3 map";
      else if (!fmt_jeida_i)           tag = "R5 map";
      else                             tag = "R6 map";
      chk(tag, 48'({lane_a_o, lane_b_o, lane_c_o, lane_d_o, lane_e_o}), 48'(ew));
      if (en) chk("R1 de bit", 48'(lane_c_o[6]), 48'(m_cur.de));
      if (en && m_cur.de) chk("R9 sync hold", 48'(lane_c_o[5:4]), 48'({m_hvs, m_hhs}));
      chk("R4 lane E flag", 48'(lane_e_on_o), 48'(deep_i));
      if (!deep_i) chk("R4 idle bits", 48'({lane_d_o[6], lane_e_o}), 48'h0);
      chk("R10 hiz", 48'(hiz_o), 48'(!en && !pat_low_i));
      chk("R11 run flag", 48'(run_err_o), 48'(m_err));
      @(posedge clk);
      m_err = (p.de != m_cur.de) && m_seen && (m_len < 8);
      if (p.de != m_cur.de) begin
         m_seen = 1'b1;
         m_len  = 1;
      end else begin
         m_len++;
      end
      m_prevde = m_cur.de;
      if (!m_cur.de) begin
         m_hhs = m_cur.hs;
         m_hvs = m_cur.vs;
      end
      m_cur = p;
      #1;
   endtask

   task automatic run(input logic de, input int n);
      for (int i = 0; i < n; i++) step(mk(de));
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      m_cur = '0; m_prevde = 1'b0; m_hhs = 1'b0; m_hvs = 1'b0;
      m_err = 1'b0; m_len = 0; m_seen = 1'b0;
      de_i = 1'b1; r_i = 10'h3ff; b_i = 10'h3ff;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R12 reset words", 48'({lane_a_o, lane_b_o, lane_c_o, lane_d_o, lane_e_o}), 48'h0);
      chk("R12 reset flags", 48'({hiz_o, run_err_o}), 48'h0);
      @(posedge clk);
      #1 rst_n = 1'b1;

      // random frames in every format and depth
      for (int m = 0; m < 4; m++) begin
         fmt_jeida_i = m[0];
         deep_i      = m[1];
         for (int ln = 0; ln < 6; ln++) begin
            run(1'b1, 8 + int'($urandom_range(0, 12)));
            run(1'b0, 8 + int'($urandom_range(0, 10)));
         end
      end

      // R11 directed: short runs, 7 against 8
      fmt_jeida_i = 1'b1; deep_i = 1'b1;
      run(1'b1, 7);
      run(1'b0, 8);
      run(1'b1, 8);
      run(1'b0, 3);
      run(1'b1, 1);
      run(1'b0, 10);

      // R10 directed: disabled output in both patterns, then link down
      oe_i = 1'b0; pat_low_i = 1'b0;
      run(1'b1, 8);
      pat_low_i = 1'b1;
      run(1'b0, 8);
      oe_i = 1'b1; lock_i = 1'b0; pat_low_i = 1'b0;
      run(1'b1, 8);
      lock_i = 1'b1;
      run(1'b0, 8);
      run(1'b1, 9);
      run(1'b0, 9);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule